// File: doc/BRIEF.md
# Low-Order Interleaved Memory Controller

This block takes a stream of single-word requests and spreads them over a set of memory banks, one request per clock at most. Each bank needs a fixed number of cycles to complete an access. The bank is chosen from the lowest address bits, so consecutive words land in different banks and their accesses run side by side. Each bank has its own holding registers for the address and the write data, so several accesses can be in flight at once. With at least as many banks as the access time in cycles, a run of consecutive addresses goes through at one word per clock.

A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. `reqReady` drops only when the addressed bank is still working on an earlier access. Read data comes back on `rspData` with a one-cycle `rspValid` strobe, in the order the reads were accepted. Writes use the same path and return nothing.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: The bank index is `reqAddr[BSEL_W-1:0]` (address modulo BANKS). The row inside the bank is `reqAddr[ADDR_W-1:BSEL_W]`. Every one of the 2^ADDR_W addresses holds its own word.
- R2: For a read accepted at clock edge E, `rspValid` is high for exactly one cycle, after edge E+ACCESS_CYCLES. In that cycle `rspData` holds the word stored at the address of that read.
- R3: With BANKS >= ACCESS_CYCLES, a run of consecutive addresses is accepted on every clock with `reqReady` never low. The reads of such a run return one word per cycle.
- R4: A bank accepted at edge E takes no new request before edge E+ACCESS_CYCLES. `reqReady` is low for a request to that bank until then, and such a request is accepted on exactly that edge.
- R5: Responses come out in the order the reads were accepted.
- R6: A write (`reqWrite`=1) stores `reqWdata` at its address and never raises `rspValid`. A later read of that address returns the written word.
- R7: While and right after reset, `rspValid` is low and `reqReady` is high.
- R8: `reqReady` depends only on the addressed bank. A request to a free bank is accepted while other banks are busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Addressed bank can take the request |
| rspValid | output | 1 | Read data valid strobe |
| rspData | output | DATA_W | Read data |

## Verification
The bench first writes every address in sequence. It then reads a consecutive run, which shows that overlapping banks hide the access time (no stalls, one response per cycle). A stride equal to the bank count keeps hitting one bank, so every request waits the full access time; this separates per-bank busy tracking from a global stall. A stride of two and a pattern that comes back to a bank after one other bank show partial waits of ACCESS_CYCLES-2 cycles. They also show that a request to a different bank goes ahead while another bank is busy. Each stall count and each response cycle is predicted from the last acceptance time of each bank, kept by the bench.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Per-bank strobes from control to datapath
  typedef struct packed {
    logic load;    // capture request into this bank's holding registers
    logic fire;    // access completes at this edge
    logic isRead;  // the completing access is a read
  } bankStrobe_t;
endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ACCESS_CYCLES = 4,
  localparam int BSEL_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int CNT_W = $clog2(ACCESS_CYCLES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic [BSEL_W-1:0] bankSel,
  output logic reqReady,
  output bankStrobe_t [BANKS-1:0] strobes
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(ACCESS_CYCLES);

  logic [BANKS-1:0] bankFree;
  logic [BANKS-1:0] fireVec;
  logic accept;

  assign reqReady = bankFree[bankSel];
  assign accept = reqValid && reqReady;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] remain;
    logic pendWrite;
    logic loadHere;

    assign loadHere = accept && (bankSel == BSEL_W'(b));
    // Free on the edge where the current access retires
    assign bankFree[b] = (remain <= CNT_W'(1));
    assign fireVec[b] = (remain == CNT_W'(1));
    assign strobes[b].load = loadHere;
    assign strobes[b].fire = fireVec[b];
    assign strobes[b].isRead = !pendWrite;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        remain <= '0;
        pendWrite <= 1'b0;
      end else if (loadHere) begin
        remain <= LOAD_VAL;
        pendWrite <= reqWrite;
      end else if (remain != '0) begin
        remain <= remain - CNT_W'(1);
      end
    end

    if (ACCESS_CYCLES > 1) begin : g_chk
      // R4: a bank is never reloaded on two consecutive edges
      p_no_backtoback_r4: assert property (@(posedge clk) disable iff (!rstN)
        strobes[b].load |=> !strobes[b].load);
    end
  end

  // R5: at most one access retires per cycle, keeping issue order
  p_single_fire_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fireVec));
endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int BSEL_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int ROW_W = ADDR_W - $clog2(BANKS),
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ROW_W-1:0] rowIn,
  input  logic [DATA_W-1:0] wdataIn,
  input  bankStrobe_t [BANKS-1:0] strobes,
  output logic rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic [DATA_W-1:0] rdWord [BANKS];
  logic [BANKS-1:0] readFire;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [ROW_W-1:0] rowHold;
    logic [DATA_W-1:0] dataHold;
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes[b].fire && !strobes[b].isRead)
        cells[rowHold] <= dataHold;
      if (strobes[b].load) begin
        rowHold <= rowIn;
        dataHold <= wdataIn;
      end
    end

    assign rdWord[b] = cells[rowHold];
    assign readFire[b] = strobes[b].fire && strobes[b].isRead;
  end

  logic [DATA_W-1:0] pick;
  always_comb begin
    pick = '0;
    for (int b = 0; b < BANKS; b++)
      if (readFire[b]) pick = rdWord[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
    end else begin
      rspValid <= |readFire;
    end
    if (|readFire) rspData <= pick;
  end

  // R2: a retiring read yields a response strobe on the next cycle
  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|readFire) |=> rspValid);
  // R6: no retiring read (idle or write only) means no response
  p_no_rsp_on_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(|readFire) |=> !rspValid);
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
  import ilv_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ACCESS_CYCLES = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int BSEL_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int ROW_W = ADDR_W - $clog2(BANKS)
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic reqReady,
  output logic rspValid,
  output logic [DATA_W-1:0] rspData
);
  bankStrobe_t [BANKS-1:0] strobes;
  logic [BSEL_W-1:0] bankSel;
  logic [ROW_W-1:0] rowSel;

  if (BANKS > 1) begin : g_sel
    assign bankSel = reqAddr[BSEL_W-1:0];
  end else begin : g_one
    assign bankSel = '0;
  end
  assign rowSel = reqAddr[ADDR_W-1:ADDR_W-ROW_W];

  ilv_ctrl #(.BANKS(BANKS), .ACCESS_CYCLES(ACCESS_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .bankSel(bankSel), .reqReady(reqReady), .strobes(strobes)
  );

  ilv_datapath #(.BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .rowIn(rowSel), .wdataIn(reqWdata),
    .strobes(strobes), .rspValid(rspValid), .rspData(rspData)
  );
endmodule

// File: tb/sim_ilv_mem_ctrl.sv
module sim_ilv_mem_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BANKS = 4;
  localparam int LAT = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int WORDS = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic reqReady, rspValid;
  logic [DATA_W-1:0] rspData;

  ilv_mem_ctrl #(.BANKS(BANKS), .ACCESS_CYCLES(LAT), .ADDR_W(ADDR_W),
                 .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [DATA_W-1:0] data; int due; int addr; } expItem_t;
  expItem_t expQ[$];
  logic [DATA_W-1:0] refMem [WORDS];
  int lastAccept [BANKS];
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  int totStalls;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DATA_W-1:0] pattern(int a);
    return DATA_W'(a * 37) ^ 16'hA5C3;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // Driver: predicts the stall count from each bank's last acceptance edge
  task automatic issue(bit w, int a, string req);
    int stalls, expStalls, bank, edgeNow;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = ADDR_W'(a);
    reqWdata = pattern(a) ^ (w ? 16'h0F0F : 16'h0);
    bank = a % BANKS;
    expStalls = lastAccept[bank] + LAT - (cyc + 1);
    if (expStalls < 0) expStalls = 0;
    stalls = 0;
    #1;
    while (!reqReady && stalls < 4 * LAT) begin
      @(negedge clk); #1; stalls++;
    end
    check(stalls == expStalls, req, stalls, expStalls);
    edgeNow = cyc + 1;
    lastAccept[bank] = edgeNow;
    totStalls += stalls;
    if (w) refMem[a] = pattern(a) ^ 16'h0F0F;
    else expQ.push_back('{refMem[a], edgeNow + LAT, a});
  endtask

  task automatic idle(int n);
    @(negedge clk); reqValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares responses against the scoreboard
  always @(negedge clk) begin
    #2;
    if (rstN && !done && rspValid) begin
      if (expQ.size() == 0) begin
        check(0, "R6 unexpected response", 1, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(cyc == it.due, "R2 response cycle", cyc, it.due);
        check(rspData == it.data, "R5/R1 response data", int'(rspData), int'(it.data));
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < BANKS; b++) lastAccept[b] = -1000;
    repeat (3) @(negedge clk);
    #1;
    check(rspValid == 1'b0, "R7 rspValid in reset", int'(rspValid), 0);
    check(reqReady == 1'b1, "R7 reqReady in reset", int'(reqReady), 1);
    @(negedge clk); rstN = 1'b1;
    #1;
    check(rspValid == 1'b0, "R7 rspValid after reset", int'(rspValid), 0);
    check(reqReady == 1'b1, "R7 reqReady after reset", int'(reqReady), 1);

    // R6/R1: fill every address with writes, sequential so no stalls (R3)
    totStalls = 0;
    for (int a = 0; a < WORDS; a++) issue(1, a, "R6 write stall");
    check(totStalls == 0, "R3 write run stalls", totStalls, 0);
    idle(2 * LAT);

    // R3: consecutive reads at one word per cycle
    totStalls = 0;
    for (int a = 0; a < 64; a++) issue(0, a, "R3 sequential read stall");
    check(totStalls == 0, "R3 sequential run stalls", totStalls, 0);
    idle(2 * LAT);

    // R4: same bank every request
    for (int k = 0; k < 6; k++) issue(0, 16 + k * BANKS, "R4 same-bank stall");
    idle(2 * LAT);

    // R8: stride two (two banks alternate), partial stalls
    for (int k = 0; k < 6; k++) issue(0, 100 + 2 * k, "R8 stride-two stall");
    idle(2 * LAT);

    // R8: revisit a bank after one other bank
    issue(0, 200, "R8 first bank");
    issue(0, 201, "R8 other bank while busy");
    issue(0, 204, "R4 revisit bank");
    idle(2 * LAT);

    // R6/R1: overwrite two rows of one bank, then read them and a neighbour
    issue(1, 9, "R6 overwrite");
    issue(1, 13, "R6 overwrite");
    issue(0, 9, "R6 read after write");
    issue(0, 13, "R6 read after write");
    issue(0, 10, "R1 neighbour read");
    idle(3 * LAT);

    check(expQ.size() == 0, "R5 all responses returned", expQ.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule